// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block supplies the column address for every beat of a synchronous DRAM burst. A command strobe loads a start column together with a mode word, which selects the burst length, the beat ordering and the write mode. From the next clock on, the block presents one column address per cycle while its advance enable is high. It raises a last-beat flag on the final beat of a fixed-length burst and then goes idle.

Beats follow one of two orderings. In sequential order the low bits of the column count up and wrap inside the burst window. In interleaved order the beat index is XORed into the low bits of the start column. A full-page burst steps through the whole 256-column page and keeps wrapping until a stop request ends it. A new command that arrives during a burst drops the rest of that burst and starts a new full-length burst at the new column. A stop request outside a full-page burst is flagged as an error. Mode words with a reserved setting are flagged as well and start no burst.

Top module: `burst_col_gen`

## Requirements
- R1: After reset, beatValid, lastBeat, modeErr and stopErr are 0 and colAddr is 0.
- R2: The length field modeWord[2:0] sets the number of beats a burst presents with advance held high: 000 gives 1, 001 gives 2, 010 gives 4, 011 gives 8 and 111 gives a full-page burst.
- R3: When modeWord[3]=0 (sequential), beat k carries the start column with its low log2(BL) bits replaced by (start + k) modulo BL. Higher bits never change. For example, start 0x0E with BL 4 gives 0x0E, 0x0F, 0x0C, 0x0D.
- R4: When modeWord[3]=1 (interleaved), beat k carries the start column with its low log2(BL) bits replaced by (start XOR k). For example, start 0x05 with BL 8 gives 05, 04, 07, 06, 01, 00, 03, 02.
- R5: In full-page mode the 8-bit column increments by one per advancing cycle, wraps from 0xFF to 0x00, and continues with lastBeat held at 0.
- R6: lastBeat is 1 exactly on the final beat of a fixed-length burst. If advance is high on that beat, beatValid is 0 in the next cycle.
- R7: A load during a burst drops the remaining beats and starts a new full-length burst at the new column. When a load and a stop request fall in the same cycle, the load wins and no stop error is raised.
- R8: A stop request during a full-page burst ends it, so beatValid is 0 in the next cycle. Any other stop request without a load gives stopErr=1 for one cycle and leaves a running burst unchanged.
- R9: When modeWord[9]=1, a write load (cmdIsWrite=1) produces exactly one beat. Read loads keep the programmed length.
- R10: Length codes 100, 101 and 110, and full page combined with interleaved order, give modeErr=1 in the cycle after the load and start no burst. A later valid load clears modeErr.
- R11: While advEn is 0, colAddr and the beat position hold and beatValid stays 1.
- R12: The first beat appears in the cycle after the load, and its address is the loaded start column.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| cmdLoad | input | 1 | Read or write command strobe: loads start column and mode |
| cmdIsWrite | input | 1 | The loading command is a write |
| startCol | input | 8 | Start column of the burst |
| modeWord | input | 12 | Mode word: [2:0] length, [3] order, [9] single-beat writes |
| advEn | input | 1 | Advance enable; low suspends the burst |
| stopReq | input | 1 | Burst stop request |
| colAddr | output | 8 | Column address of the current beat |
| beatValid | output | 1 | A burst beat is being presented |
| lastBeat | output | 1 | Current beat is the final one of a fixed burst |
| modeErr | output | 1 | Last loaded mode word was reserved |
| stopErr | output | 1 | Pulse: a stop request was illegal |

## Verification
A load and a stop request can fall in the same cycle. This matters most during a full-page burst, where either one alone would change the burst. The bench drives both together in a directed case. It expects the new burst at the new column with no stop error, rather than an idle block. Random stimulus also drives loads, stops and stalls together against a bench reference model, which covers the combination of stop and stall as well.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;
  localparam int MODE_W    = 12;
  localparam int LEN_LSB   = 0;
  localparam int ORDER_BIT = 3;
  localparam int WMODE_BIT = 9;

  typedef enum logic [2:0] {
    LEN_1    = 3'b000,
    LEN_2    = 3'b001,
    LEN_4    = 3'b010,
    LEN_8    = 3'b011,
    LEN_PAGE = 3'b111
  } len_code_e;

  typedef struct packed {
    logic load;
    logic step;
    logic ilv;
  } col_strobe_t;
endpackage

// File: rtl/burst_col_ctrl.sv
module burst_col_ctrl
  import burst_col_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdLoad,
  input  logic             cmdIsWrite,
  input  logic [2:0]       lenCode,
  input  logic             ilvSel,
  input  logic             singleWrSel,
  input  logic             advEn,
  input  logic             stopReq,
  input  logic [COL_W-1:0] beatIdx,
  output col_strobe_t      strobe,
  output logic [COL_W-1:0] loadMask,
  output logic             beatValid,
  output logic             lastBeat,
  output logic             modeErr,
  output logic             stopErr
);
  logic [COL_W-1:0] fixMask;
  logic             isPage;
  logic             isRsv;
  logic             decPage;
  logic             decErr;

  logic             validQ;
  logic             pageQ;
  logic [COL_W-1:0] lastIdxQ;
  logic             modeErrQ;
  logic             stopErrQ;

  always_comb begin
    fixMask = '0;
    isPage  = 1'b0;
    isRsv   = 1'b0;
    case (len_code_e'(lenCode))
      LEN_1:    fixMask = '0;
      LEN_2:    fixMask = COL_W'(1);
      LEN_4:    fixMask = COL_W'(3);
      LEN_8:    fixMask = COL_W'(7);
      LEN_PAGE: begin
        fixMask = '1;
        isPage  = 1'b1;
      end
      default:  isRsv = 1'b1;
    endcase
  end

  assign decErr   = isRsv || (isPage && ilvSel);
  assign decPage  = isPage && !(singleWrSel && cmdIsWrite);
  assign loadMask = (singleWrSel && cmdIsWrite) ? '0 : fixMask;

  assign lastBeat = validQ && !pageQ && (beatIdx == lastIdxQ);

  assign strobe.load = cmdLoad;
  assign strobe.ilv  = ilvSel;
  assign strobe.step = !cmdLoad && validQ && advEn && !lastBeat
                       && !(pageQ && stopReq);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ   <= 1'b0;
      pageQ    <= 1'b0;
      lastIdxQ <= '0;
      modeErrQ <= 1'b0;
      stopErrQ <= 1'b0;
    end else begin
      stopErrQ <= stopReq && !cmdLoad && !(validQ && pageQ);
      if (cmdLoad) begin
        validQ   <= !decErr;
        pageQ    <= decPage;
        lastIdxQ <= loadMask;
        modeErrQ <= decErr;
      end else if (validQ && pageQ && stopReq) begin
        validQ <= 1'b0;
      end else if (validQ && advEn && lastBeat) begin
        validQ <= 1'b0;
      end
    end
  end

  assign beatValid = validQ;
  assign modeErr   = modeErrQ;
  assign stopErr   = stopErrQ;
endmodule

// File: rtl/burst_col_dp.sv
module burst_col_dp
  import burst_col_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  col_strobe_t      strobe,
  input  logic [COL_W-1:0] startCol,
  input  logic [COL_W-1:0] loadMask,
  output logic [COL_W-1:0] beatIdx,
  output logic [COL_W-1:0] colAddr
);
  logic [COL_W-1:0] startQ;
  logic [COL_W-1:0] idxQ;
  logic [COL_W-1:0] maskQ;
  logic             ilvQ;
  logic [COL_W-1:0] seqLow;
  logic [COL_W-1:0] ilvLow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startQ <= '0;
      idxQ   <= '0;
      maskQ  <= '0;
      ilvQ   <= 1'b0;
    end else if (strobe.load) begin
      startQ <= startCol;
      idxQ   <= '0;
      maskQ  <= loadMask;
      ilvQ   <= strobe.ilv;
    end else if (strobe.step) begin
      idxQ <= idxQ + COL_W'(1);
    end
  end

  assign seqLow = startQ + idxQ;
  assign ilvLow = startQ ^ idxQ;

  for (genvar b = 0; b < COL_W; b++) begin : g_bit
    assign colAddr[b] = maskQ[b] ? (ilvQ ? ilvLow[b] : seqLow[b]) : startQ[b];
  end

  assign beatIdx = idxQ;
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import burst_col_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdLoad,
  input  logic              cmdIsWrite,
  input  logic [COL_W-1:0]  startCol,
  input  logic [MODE_W-1:0] modeWord,
  input  logic              advEn,
  input  logic              stopReq,
  output logic [COL_W-1:0]  colAddr,
  output logic              beatValid,
  output logic              lastBeat,
  output logic              modeErr,
  output logic              stopErr
);
  col_strobe_t      strobe;
  logic [COL_W-1:0] loadMask;
  logic [COL_W-1:0] beatIdx;
  logic             unusedModeBits;

  assign unusedModeBits = ^{modeWord[MODE_W-1:WMODE_BIT+1],
                            modeWord[WMODE_BIT-1:ORDER_BIT+1]};

  burst_col_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .cmdLoad     (cmdLoad),
    .cmdIsWrite  (cmdIsWrite),
    .lenCode     (modeWord[LEN_LSB+2:LEN_LSB]),
    .ilvSel      (modeWord[ORDER_BIT]),
    .singleWrSel (modeWord[WMODE_BIT]),
    .advEn       (advEn),
    .stopReq     (stopReq),
    .beatIdx     (beatIdx),
    .strobe      (strobe),
    .loadMask    (loadMask),
    .beatValid   (beatValid),
    .lastBeat    (lastBeat),
    .modeErr     (modeErr),
    .stopErr     (stopErr)
  );

  burst_col_dp #(.COL_W(COL_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .startCol (startCol),
    .loadMask (loadMask),
    .beatIdx  (beatIdx),
    .colAddr  (colAddr)
  );
endmodule

// File: rtl/burst_col_chk.sv
module burst_col_chk #(
  parameter int COL_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             cmdLoad,
  input logic [COL_W-1:0] startCol,
  input logic             advEn,
  input logic             stopReq,
  input logic [COL_W-1:0] colAddr,
  input logic             beatValid,
  input logic             lastBeat,
  input logic             modeErr,
  input logic             stopErr
);
  // R11
  hold_when_stalled_chk: assert property (@(posedge clk) disable iff (!rstN)
    beatValid && !advEn && !cmdLoad && !stopReq |=> beatValid && $stable(colAddr));

  // R6
  last_ends_burst_chk: assert property (@(posedge clk) disable iff (!rstN)
    lastBeat && advEn && !cmdLoad |=> !beatValid);

  // R6
  last_needs_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    lastBeat |-> beatValid);

  // R12
  first_beat_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdLoad |=> !beatValid || (colAddr == $past(startCol)));

  // R10
  load_outcome_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdLoad |=> (beatValid != modeErr));

  // R8
  idle_stop_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    stopReq && !cmdLoad && !beatValid |=> stopErr);
endmodule

bind burst_col_gen burst_col_chk #(.COL_W(COL_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .cmdLoad   (cmdLoad),
  .startCol  (startCol),
  .advEn     (advEn),
  .stopReq   (stopReq),
  .colAddr   (colAddr),
  .beatValid (beatValid),
  .lastBeat  (lastBeat),
  .modeErr   (modeErr),
  .stopErr   (stopErr)
);

// File: tb/burst_col_gen_test.sv
module burst_col_gen_test;
  localparam int CLK_PERIOD = 10;
  localparam int COL_W = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdLoad = 1'b0;
  logic        cmdIsWrite = 1'b0;
  logic [7:0]  startCol = '0;
  logic [11:0] modeWord = '0;
  logic        advEn = 1'b1;
  logic        stopReq = 1'b0;
  logic [7:0]  colAddr;
  logic        beatValid, lastBeat, modeErr, stopErr;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_col_gen #(.COL_W(COL_W)) uut (
    .clk(clk), .rstN(rstN), .cmdLoad(cmdLoad), .cmdIsWrite(cmdIsWrite),
    .startCol(startCol), .modeWord(modeWord), .advEn(advEn), .stopReq(stopReq),
    .colAddr(colAddr), .beatValid(beatValid), .lastBeat(lastBeat),
    .modeErr(modeErr), .stopErr(stopErr)
  );

  // reference model built from the requirements
  logic       mValid = 1'b0, mFull = 1'b0, mIlv = 1'b0, mModeErr = 1'b0, mStopErr = 1'b0;
  logic [7:0] mStart = '0, mIdx = '0, mMask = '0;

  function automatic logic [7:0] expCol(logic [7:0] s, logic [7:0] k, logic [7:0] m, logic ilv);
    logic [7:0] low;
    low = ilv ? (s ^ k) : (s + k);
    return (s & ~m) | (low & m);
  endfunction

  function automatic logic mLast();
    return mValid && !mFull && (mIdx == mMask);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mValid = 0; mFull = 0; mIlv = 0; mModeErr = 0; mStopErr = 0;
      mStart = 0; mIdx = 0; mMask = 0;
    end else begin
      automatic logic stopE = stopReq && !cmdLoad && !(mValid && mFull);
      if (cmdLoad) begin
        automatic logic [7:0] m = 0;
        automatic logic full = 0, rsv = 0;
        case (modeWord[2:0])
          3'd0: m = 8'd0;
          3'd1: m = 8'd1;
          3'd2: m = 8'd3;
          3'd3: m = 8'd7;
          3'd7: begin m = 8'hFF; full = 1; end
          default: rsv = 1;
        endcase
        mModeErr = rsv || (full && modeWord[3]);
        if (modeWord[9] && cmdIsWrite) begin m = 0; full = 0; end
        mStart = startCol; mIdx = 0; mMask = m; mFull = full; mIlv = modeWord[3];
        mValid = !mModeErr;
      end else if (mValid && mFull && stopReq) begin
        mValid = 0;
      end else if (mValid && advEn) begin
        if (mLast()) mValid = 0;
        else mIdx = mIdx + 8'd1;
      end
      mStopErr = stopE;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic load(logic [7:0] s, logic [11:0] mode, logic wr);
    cmdLoad = 1; startCol = s; modeWord = mode; cmdIsWrite = wr;
    tick();
    cmdLoad = 0;
  endtask

  task automatic countBeats(string tag, int expN);
    int n = 0;
    while (beatValid && n < 20) begin
      n++;
      tick();
    end
    chk(tag, n, expN);
  endtask

  task automatic compareModel();
    string tag;
    tag = mFull ? "R5" : (mIlv ? "R4" : "R3");
    chk({tag, " valid"}, beatValid, mValid);
    if (mValid) chk({tag, " col"}, colAddr, expCol(mStart, mIdx, mMask, mIlv));
    chk("R6 last", lastBeat, mLast());
    chk("R10 modeErr", modeErr, mModeErr);
    chk("R8 stopErr", stopErr, mStopErr);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  logic [7:0] seqExp [4] = '{8'h0E, 8'h0F, 8'h0C, 8'h0D};
  logic [7:0] ilvExp [8] = '{8'h05, 8'h04, 8'h07, 8'h06, 8'h01, 8'h00, 8'h03, 8'h02};

  initial begin
    void'($urandom(32'h1234_5eed));
    tick(); tick();
    // R1 reset state
    chk("R1 valid", beatValid, 0);
    chk("R1 last", lastBeat, 0);
    chk("R1 modeErr", modeErr, 0);
    chk("R1 stopErr", stopErr, 0);
    chk("R1 col", colAddr, 0);
    rstN = 1;
    tick();

    // R3 R12 R6: BL4 sequential
    load(8'h0E, 12'h002, 0);
    for (int i = 0; i < 4; i++) begin
      chk(i == 0 ? "R12 first col" : "R3 seq col", colAddr, seqExp[i]);
      chk("R6 last", lastBeat, i == 3);
      tick();
    end
    chk("R6 valid after last", beatValid, 0);

    // R4 BL8 interleaved
    load(8'h05, 12'h00B, 0);
    for (int i = 0; i < 8; i++) begin
      chk("R4 ilv col", colAddr, ilvExp[i]);
      tick();
    end

    // R2 beat counts
    load(8'h40, 12'h000, 0); countBeats("R2 BL1", 1);
    load(8'h40, 12'h001, 0); countBeats("R2 BL2", 2);
    load(8'h40, 12'h002, 0); countBeats("R2 BL4", 4);
    load(8'h40, 12'h003, 0); countBeats("R2 BL8", 8);

    // R5 full page with wrap, then R8 stop
    load(8'hFE, 12'h007, 0);
    for (int i = 0; i < 300; i++) begin
      chk("R5 page col", colAddr, 8'(8'hFE + i));
      chk("R5 page last", lastBeat, 0);
      tick();
    end
    stopReq = 1; tick(); stopReq = 0;
    chk("R8 page stopped", beatValid, 0);
    chk("R8 legal stop no flag", stopErr, 0);

    // R8 illegal stop in BL8
    load(8'h30, 12'h003, 0);
    tick();
    stopReq = 1; tick(); stopReq = 0;
    chk("R8 stopErr", stopErr, 1);
    chk("R8 burst continues", beatValid, 1);
    chk("R8 col unchanged path", colAddr, 8'h32);
    tick();
    chk("R8 stopErr pulse", stopErr, 0);
    countBeats("R8 rest", 5);

    // R7 load mid-burst
    load(8'h10, 12'h003, 0);
    tick(); tick();
    load(8'h23, 12'h003, 0);
    chk("R7 new col", colAddr, 8'h23);
    countBeats("R7 full length", 8);

    // R7 load and stop together in full page
    load(8'h80, 12'h007, 0);
    tick();
    cmdLoad = 1; startCol = 8'h55; stopReq = 1;
    tick();
    cmdLoad = 0; stopReq = 0;
    chk("R7 load wins valid", beatValid, 1);
    chk("R7 load wins col", colAddr, 8'h55);
    chk("R7 no stopErr", stopErr, 0);
    stopReq = 1; tick(); stopReq = 0;

    // R9 single-beat writes
    load(8'h08, 12'h203, 1); countBeats("R9 write single", 1);
    load(8'h08, 12'h203, 0); countBeats("R9 read full", 8);

    // R10 reserved settings
    load(8'h00, 12'h005, 0);
    chk("R10 rsv err", modeErr, 1);
    chk("R10 rsv no burst", beatValid, 0);
    load(8'h00, 12'h00F, 0);
    chk("R10 page ilv err", modeErr, 1);
    chk("R10 page ilv no burst", beatValid, 0);
    load(8'h00, 12'h000, 0);
    chk("R10 cleared", modeErr, 0);
    tick();

    // R11 advance hold
    load(8'h60, 12'h003, 0);
    advEn = 0;
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R11 hold col", colAddr, 8'h60);
      chk("R11 hold valid", beatValid, 1);
    end
    advEn = 1; tick();
    chk("R11 resume", colAddr, 8'h61);
    countBeats("R11 rest", 7);

    // random phase against the model
    for (int c = 0; c < 4000; c++) begin
      automatic logic [2:0] codes [6] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd7, 3'd6};
      compareModel();
      cmdLoad    = ($urandom % 8) == 0;
      startCol   = 8'($urandom);
      modeWord   = {2'b00, 1'($urandom % 2), 5'b0, 1'($urandom % 2), codes[$urandom % 6]};
      cmdIsWrite = 1'($urandom % 2);
      advEn      = ($urandom % 5) != 0;
      stopReq    = ($urandom % 12) == 0;
      tick();
    end
    summary();
  end
endmodule